// File: doc/BRIEF.md
# Internal Oscillator Clock-Enable Divider

This block sits in the clock domain of a 48 MHz on-chip high-speed oscillator. From that clock it produces three clock-enable strobes rather than gated clocks: a system-clock candidate, a fixed phase-locked-loop reference, and a flash-controller clock. Logic downstream runs on the oscillator clock and advances only on cycles where its strobe is high. A strobe high on every cycle stands for the full 48 MHz rate. A strobe high on one cycle in six stands for 8 MHz. A strobe high on one cycle in twelve stands for 4 MHz.

One shared modulo-12 counter produces all of the divided strobes, so they stay phase aligned. The counter divides time into 12-cycle frames. The last cycle of a frame is the one in which the reference strobe is high. Three select inputs choose the rates, and they are sampled only in that last cycle. A new rate therefore starts cleanly at a frame boundary, and no divided strobe is ever shortened or doubled.

Top module: `osc_ce_divider`

## Requirements
- R1: `ref_ce` is high on exactly one cycle in every 12, in cycle 11 of each frame. The select inputs have no effect on it.
- R2: While the applied `sys_full_en` is 0, `sys_ce` is high only in frame cycles 5 and 11, whatever `osc_div_bypass` holds.
- R3: While the applied `sys_full_en` is 1, `sys_ce` follows the applied `osc_div_bypass`. When that bit is 1, `sys_ce` is high on every cycle. When it is 0, `sys_ce` is high in frame cycles 5 and 11 only.
- R4: When the applied `fmc_full_sel` is 0, `fmc_ce` is high in frame cycles 5 and 11 only. When it is 1, `fmc_ce` is high on every cycle.
- R5: An active-low `rst_n` has the following effects:
  - It clears the counter to frame cycle 0.
  - It clears all applied selects to 0.
  - While reset is held, every strobe is low.
  - After release, the first cycle is frame cycle 0.
  - The first `sys_ce` and `fmc_ce` pulses come 5 cycles after release, and the first `ref_ce` pulse comes 11 cycles after release.
- R6: In every cycle in which `ref_ce` is high, `sys_ce` and `fmc_ce` are also high.
- R7: The select inputs are sampled only in the cycle in which `ref_ce` is high, and they take effect from the next cycle. A change made in any other cycle has no effect on the strobes of the current frame.
- R8: A divided strobe is exactly six cycles from one pulse to the next, and it never stays high for two consecutive cycles within a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 48 MHz oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_div_bypass | input | 1 | 1 selects the undivided oscillator for the system candidate; 0 selects divide-by-6 |
| sys_full_en | input | 1 | 0 forces the system candidate to divide-by-6; 1 lets `osc_div_bypass` decide |
| fmc_full_sel | input | 1 | 1 selects the undivided oscillator for the flash controller; 0 selects divide-by-6 |
| sys_ce | output | 1 | System-clock candidate enable |
| ref_ce | output | 1 | Fixed divide-by-12 reference enable |
| fmc_ce | output | 1 | Flash-controller clock enable |

## Verification
A wrong counter value appears as a `ref_ce` pulse that comes early or late. It also moves the divided `sys_ce` and `fmc_ce` pulses off cycles 5 and 11 of the frame. This shows within one 12-cycle frame. A select register that loads outside the frame boundary, or that fails to load, is visible in the frame that follows the change. In that frame the strobe density is 12 pulses where 2 were expected, or 2 where 12 were expected. The bench measures strobe counts per frame, and it measures the exact cycles of the first pulses after reset.

// File: rtl/osc_ce_divider.sv
module osc_ce_divider #(
  parameter int SYS_DIV = 6,
  parameter int REF_DIV = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_div_bypass,
  input  logic sys_full_en,
  input  logic fmc_full_sel,
  output logic sys_ce,
  output logic ref_ce,
  output logic fmc_ce
);

  localparam int CW = $clog2(REF_DIV);
  localparam int GW = CW + 1;
  localparam logic [CW-1:0] LAST = CW'(REF_DIV - 1);

  logic [CW-1:0] cnt;
  logic byp_q, full_q, fmc_q;
  logic slow_tick, wrap;

  assign wrap      = (cnt == LAST);
  assign slow_tick = ((int'(cnt) % SYS_DIV) == SYS_DIV - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      byp_q  <= 1'b0;
      full_q <= 1'b0;
      fmc_q  <= 1'b0;
    end else begin
      cnt <= wrap ? '0 : cnt + 1'b1;
      if (wrap) begin
        byp_q  <= osc_div_bypass;
        full_q <= sys_full_en;
        fmc_q  <= fmc_full_sel;
      end
    end
  end

  assign ref_ce = rst_n & wrap;
  assign sys_ce = rst_n & ((full_q & byp_q) | slow_tick);
  assign fmc_ce = rst_n & (fmc_q | slow_tick);

  // checker state: cycles since the last reference pulse
  logic [GW-1:0] ref_gap;
  logic          ref_seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_gap  <= '0;
      ref_seen <= 1'b0;
    end else if (ref_ce) begin
      ref_gap  <= '0;
      ref_seen <= 1'b1;
    end else begin
      ref_gap <= ref_gap + 1'b1;
    end
  end

  a_r1_ref_period: assert property (@(posedge clk) disable iff (!rst_n)
    ref_ce && ref_seen |-> ref_gap == GW'(REF_DIV - 1));

  a_r2_forced_slow: assert property (@(posedge clk) disable iff (!rst_n)
    !full_q && sys_ce && !ref_ce |=> !sys_ce);

  a_r3_full_rate: assert property (@(posedge clk) disable iff (!rst_n)
    full_q && byp_q |-> sys_ce);

  a_r4_fmc_full: assert property (@(posedge clk) disable iff (!rst_n)
    fmc_q |-> fmc_ce);

  a_r6_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    ref_ce |-> sys_ce && fmc_ce);

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_ce |=> $stable({byp_q, full_q, fmc_q}));

  a_r8_no_double: assert property (@(posedge clk) disable iff (!rst_n)
    !fmc_q && fmc_ce && !ref_ce |=> !fmc_ce);

endmodule

// File: tb/test_osc_ce_divider.sv
module test_osc_ce_divider;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic byp = 1'b0, full = 1'b0, fsel = 1'b0;
  logic sys_ce, ref_ce, fmc_ce;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  osc_ce_divider i_osc_ce_divider (
    .clk(clk), .rst_n(rst_n), .osc_div_bypass(byp), .sys_full_en(full),
    .fmc_full_sel(fsel), .sys_ce(sys_ce), .ref_ce(ref_ce), .fmc_ce(fmc_ce)
  );

  // {bypass, full_en, fmc_sel, exp sys pulses/frame, exp fmc pulses/frame}
  localparam int VEC [8][5] = '{
    '{0,0,0, 2, 2}, '{1,0,0, 2, 2}, '{0,1,0, 2, 2}, '{1,1,0,12, 2},
    '{0,0,1, 2,12}, '{1,0,1, 2,12}, '{0,1,1, 2,12}, '{1,1,1,12,12}
  };

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic sync_frame();
    @(negedge clk);
    while (!ref_ce) @(negedge clk);
  endtask

  // counts strobes over 12 samples starting with the current negedge
  task automatic count_frame(output int s, output int r, output int f,
                             output int rpos, output int align);
    s = 0; r = 0; f = 0; rpos = -1; align = 1;
    for (int k = 0; k < 12; k++) begin
      if (k > 0) @(negedge clk);
      s += int'(sys_ce); r += int'(ref_ce); f += int'(fmc_ce);
      if (ref_ce) begin
        rpos = k;
        if (!(sys_ce && fmc_ce)) align = 0;
      end
    end
  endtask

  initial begin
    int s, r, f, rp, al, first_sys, first_ref, first_fmc;
    // R5: reset state
    repeat (3) @(negedge clk);
    check("R5 strobes in reset", int'({sys_ce, ref_ce, fmc_ce}), 0);
    rst_n = 1'b1;
    #1;
    first_sys = -1; first_ref = -1; first_fmc = -1;
    for (int k = 0; k < 12; k++) begin
      if (k > 0) @(negedge clk);
      if (sys_ce && first_sys < 0) first_sys = k;
      if (fmc_ce && first_fmc < 0) first_fmc = k;
      if (ref_ce && first_ref < 0) first_ref = k;
    end
    check("R5 first sys_ce", first_sys, 5);
    check("R5 first fmc_ce", first_fmc, 5);
    check("R5 first ref_ce", first_ref, 11);

    // vector table: inputs driven in the boundary cycle apply to next frame
    for (int v = 0; v < 8; v++) begin
      sync_frame();
      byp = VEC[v][0][0]; full = VEC[v][1][0]; fsel = VEC[v][2][0];
      @(negedge clk);
      count_frame(s, r, f, rp, al);
      check($sformatf("R2/R3 sys count vec%0d", v), s, VEC[v][3]);
      check($sformatf("R4 fmc count vec%0d", v), f, VEC[v][4]);
      check($sformatf("R1 ref count vec%0d", v), r, 1);
      check($sformatf("R1 ref position vec%0d", v), rp, 11);
      check($sformatf("R6 alignment vec%0d", v), al, 1);
    end

    // R7: mid-frame change ignored until the next boundary
    byp = 1'b0; full = 1'b0; fsel = 1'b0;
    sync_frame();
    @(negedge clk);
    count_frame(s, r, f, rp, al);
    check("R2 settle slow", s, 2);
    @(negedge clk);
    @(negedge clk);
    byp = 1'b1; full = 1'b1; fsel = 1'b1;
    while (!ref_ce) @(negedge clk);
    check("R7 sys unchanged before boundary", int'(sys_ce), 1);
    @(negedge clk);
    count_frame(s, r, f, rp, al);
    check("R7 sys fast after boundary", s, 12);
    check("R7 fmc fast after boundary", f, 12);

    // R7: pulse in frame where change lands mid-frame
    sync_frame();
    @(negedge clk);
    byp = 1'b0; full = 1'b0; fsel = 1'b0;
    count_frame(s, r, f, rp, al);
    check("R7 old rate held in frame", s, 12);
    @(negedge clk);
    count_frame(s, r, f, rp, al);
    check("R7 new rate next frame", s, 2);

    // R8: spacing of divided pulses, and R2 with bypass set alone
    byp = 1'b1;
    sync_frame();
    @(negedge clk);
    first_sys = -1; first_fmc = -1; s = 0;
    for (int k = 0; k < 12; k++) begin
      if (k > 0) @(negedge clk);
      if (sys_ce) begin
        if (first_sys < 0) first_sys = k; else first_fmc = k;
        s++;
      end
    end
    check("R8 first divided pulse", first_sys, 5);
    check("R8 second divided pulse", first_fmc, 11);
    check("R2 bypass alone stays slow", s, 2);
    done = 1'b1;
  end

  initial begin
    fork
      begin : wd
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
      wait (done);
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule